// File: doc/BRIEF.md
# Timer Compare-Match Waveform Unit

This block pairs an 8-bit timer counter with a compare register and an equality detector. The counter advances only on cycles where the timer tick enable is high. It can wrap freely, clear itself after a match, or bounce between zero and its maximum value. When the count equals the active compare value, the block records a match. On the following tick it raises a compare flag, and it can turn that flag into an interrupt request. The same match, together with the top and bottom of the count, drives a single waveform pin. The pin's behaviour depends on the selected wave mode and output mode.

Software reaches the block through a small register port with four addresses: control (0), compare value (1), flag (2) and counter (3, read-only). In the two PWM wave modes the compare value is double buffered. A write lands in a buffer and reaches the comparator only at a fixed point of the count sequence, so a pulse period can never be cut short or made lopsided. In the other two modes a write goes straight to the comparator.

Top module: `oc_unit`

## Requirements
- R1: The counter changes only on a cycle with `tick` high, by one step. In wave modes 00 (normal) and 11 (fast PWM) it counts up and wraps from 0xFF to 0x00. Its value is read at address 3.
- R2: In wave mode 10 (clear on match), a tick while the count equals the active compare value sets the count to 0x00.
- R3: In wave mode 01 (phase-correct PWM), a tick at 0xFF while counting up gives 0xFE, and the counter then counts down. A tick at 0x00 while counting down gives 0x01, and the counter then counts up.
- R4: A tick that sees count equal to the active compare value sets the flag (address 2, bit 0) on the next tick, not earlier. Idle cycles in between do not set it.
- R5: `irq` is high exactly while the flag is 1 and the interrupt enable (control bit 4) is 1.
- R6: The flag clears on a cycle with `irq_ack` high, or on a write to address 2 with bit 0 set. A write to address 2 with bit 0 clear leaves the flag unchanged.
- R7: In wave modes 01 and 11, a write to address 1 changes only the buffer, and a read of address 1 returns the buffer. The buffer is copied to the active compare value on a tick at count 0xFF in mode 01, or at count 0x00 in mode 11.
- R8: In wave modes 00 and 10, a write to address 1 changes the active compare value immediately, and a read returns it.
- R9: In wave modes 00 and 10, a tick with a match applies the output mode (control bits 3:2): 01 toggles the pin, 10 clears it, 11 sets it. Output mode 00 holds the pin low in every wave mode. Output mode 01 also holds it low in the PWM modes.
- R10: In fast PWM with output mode 10, a match tick clears the pin and a tick at count 0x00 sets it. Output mode 11 swaps set and clear. When both happen on one tick, the match wins.
- R11: In phase-correct PWM with output mode 10, a match tick clears the pin while counting up and sets it while counting down. Output mode 11 swaps these.
- R12: A control write with bit 7 set applies the written output mode's match action to the pin at once, without touching the flag, when the written wave mode is 00 or 10. It is ignored when the written wave mode is 01 or 11. Bit 7 always reads as 0.
- R13: After reset the count is 0x00 and counting up, control, compare and flag are 0, and `wave_out` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer tick enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_ack | input | 1 | Interrupt serviced strobe, clears the flag |
| count | output | 8 | Current counter value |
| at_top | output | 1 | Count is 0xFF |
| at_bottom | output | 1 | Count is 0x00 |
| irq | output | 1 | Compare interrupt request |
| wave_out | output | 1 | Waveform pin |

## Verification
The assertions check the following every cycle:
- the count is stable between ticks;
- the count clears after a match in clear-on-match mode;
- the count turns around at the top in phase-correct mode;
- the flag rises only on a tick that follows a recorded match;
- an acknowledge drops the request;
- the active compare value stays put in PWM modes except at a transfer point;
- a force strobe written with a PWM mode leaves the pin unchanged.

Only the bench scenarios can show the longer sequences: pin edges at the right counts in each output mode, the buffer taking effect one full period later, the count turning at the bottom, and the register read-back values.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

  localparam logic [1:0] WM_NORMAL = 2'b00;
  localparam logic [1:0] WM_PHASE  = 2'b01;
  localparam logic [1:0] WM_CTC    = 2'b10;
  localparam logic [1:0] WM_FAST   = 2'b11;

  localparam logic [1:0] OM_OFF    = 2'b00;
  localparam logic [1:0] OM_TOGGLE = 2'b01;
  localparam logic [1:0] OM_CLEAR  = 2'b10;
  localparam logic [1:0] OM_SET    = 2'b11;

  localparam logic [1:0] RA_CTL  = 2'd0;
  localparam logic [1:0] RA_CMP  = 2'd1;
  localparam logic [1:0] RA_FLAG = 2'd2;
  localparam logic [1:0] RA_CNT  = 2'd3;

  localparam int CTL_FORCE_BIT = 7;

  typedef enum logic [1:0] {PA_HOLD, PA_TOGGLE, PA_CLEAR, PA_SET} pin_act_e;

  typedef struct packed {
    logic       ie;
    logic [1:0] om;
    logic [1:0] wm;
  } ctl_t;

  // PWM modes use the double-buffered compare value
  function automatic logic is_pwm(input logic [1:0] wm);
    return wm[0];
  endfunction

  // action on a match in the non-PWM modes
  function automatic pin_act_e direct_act(input logic [1:0] om);
    case (om)
      OM_TOGGLE: return PA_TOGGLE;
      OM_CLEAR:  return PA_CLEAR;
      OM_SET:    return PA_SET;
      default:   return PA_HOLD;
    endcase
  endfunction

  // action in the PWM modes; a match outranks the bottom event
  function automatic pin_act_e pwm_act(input logic [1:0] wm, input logic [1:0] om,
                                       input logic match, input logic bottom,
                                       input logic down);
    logic inv;
    inv = (om == OM_SET);
    if (om == OM_OFF || om == OM_TOGGLE) return PA_HOLD;
    if (wm == WM_FAST) begin
      if (match)  return inv ? PA_SET : PA_CLEAR;
      if (bottom) return inv ? PA_CLEAR : PA_SET;
      return PA_HOLD;
    end
    if (match) return (down ^ inv) ? PA_SET : PA_CLEAR;
    return PA_HOLD;
  endfunction

  function automatic logic apply_act(input pin_act_e a, input logic cur);
    case (a)
      PA_TOGGLE: return ~cur;
      PA_CLEAR:  return 1'b0;
      PA_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction

  function automatic logic pin_connected(input logic [1:0] wm, input logic [1:0] om);
    return !(om == OM_OFF || (is_pwm(wm) && om == OM_TOGGLE));
  endfunction

endpackage

// File: rtl/ocu_counter.sv
module ocu_counter
  import ocu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   wm,
  input  logic         match,
  output logic [W-1:0] count,
  output logic         down,
  output logic         at_top,
  output logic         at_bottom
);

  localparam logic [W-1:0] TOP_VAL = {W{1'b1}};
  localparam logic [W-1:0] ZERO    = '0;
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic         down_q;

  function automatic logic [W-1:0] step_val(input logic [1:0] m, input logic [W-1:0] c,
                                            input logic dn, input logic hit);
    case (m)
      WM_CTC:   return hit ? ZERO : c + ONE;
      WM_PHASE: begin
        if (!dn) return (c == TOP_VAL) ? TOP_VAL - ONE : c + ONE;
        return (c == ZERO) ? ONE : c - ONE;
      end
      default:  return c + ONE;
    endcase
  endfunction

  function automatic logic step_dir(input logic [1:0] m, input logic [W-1:0] c,
                                    input logic dn);
    if (m != WM_PHASE) return 1'b0;
    if (!dn && c == TOP_VAL) return 1'b1;
    if (dn && c == ZERO) return 1'b0;
    return dn;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= ZERO;
      down_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= step_val(wm, cnt_q, down_q, match);
      down_q <= step_dir(wm, cnt_q, down_q);
    end
  end

  assign count     = cnt_q;
  assign down      = down_q;
  assign at_top    = (cnt_q == TOP_VAL);
  assign at_bottom = (cnt_q == ZERO);

endmodule

// File: rtl/ocu_cmp_reg.sv
module ocu_cmp_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         buffered,
  input  logic         xfer,
  output logic [W-1:0] active,
  output logic [W-1:0] shadow
);

  logic [W-1:0] active_q;
  logic [W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      shadow_q <= '0;
    end else if (wr && !buffered) begin
      active_q <= wdata;
      shadow_q <= wdata;
    end else begin
      if (xfer) active_q <= shadow_q;
      if (wr)   shadow_q <= wdata;
    end
  end

  assign active = active_q;
  assign shadow = shadow_q;

endmodule

// File: rtl/ocu_flag.sv
module ocu_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match,
  input  logic ack,
  input  logic sw_clear,
  output logic flag,
  output logic pend
);

  logic pend_q;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (tick) pend_q <= match;
      if (tick && pend_q)        flag_q <= 1'b1;
      else if (ack || sw_clear)  flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;
  assign pend = pend_q;

endmodule

// File: rtl/ocu_wavegen.sv
module ocu_wavegen
  import ocu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] wm,
  input  logic [1:0] om,
  input  logic       match,
  input  logic       at_bottom,
  input  logic       down,
  input  logic       force_req,
  input  logic [1:0] force_wm,
  input  logic [1:0] force_om,
  output logic       wave_q,
  output logic       pin
);

  logic     state_q;
  pin_act_e tick_act;
  logic     force_ok;

  always_comb begin
    if (!is_pwm(wm)) tick_act = match ? direct_act(om) : PA_HOLD;
    else             tick_act = pwm_act(wm, om, match, at_bottom, down);
  end

  assign force_ok = force_req && !is_pwm(force_wm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= 1'b0;
    else if (force_ok) state_q <= apply_act(direct_act(force_om), state_q);
    else if (tick)     state_q <= apply_act(tick_act, state_q);
  end

  assign wave_q = state_q;
  assign pin    = pin_connected(wm, om) ? state_q : 1'b0;

endmodule

// File: rtl/oc_unit.sv
module oc_unit
  import ocu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reg_wr,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         irq_ack,
  output logic [W-1:0] count,
  output logic         at_top,
  output logic         at_bottom,
  output logic         irq,
  output logic         wave_out
);

  ctl_t         ctl_q;
  logic         wr_ctl, wr_cmp, wr_flag;
  logic         force_req;
  logic [W-1:0] cmp_active, cmp_shadow;
  logic         match_evt, xfer_evt, buffered;
  logic         flag_q, pend_q, down, wave_q;

  assign wr_ctl  = reg_wr && (reg_addr == RA_CTL);
  assign wr_cmp  = reg_wr && (reg_addr == RA_CMP);
  assign wr_flag = reg_wr && (reg_addr == RA_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= ctl_t'(reg_wdata[4:0]);
  end

  assign force_req = wr_ctl && reg_wdata[CTL_FORCE_BIT];
  assign buffered  = is_pwm(ctl_q.wm);
  assign match_evt = (count == cmp_active);
  assign xfer_evt  = tick && ((ctl_q.wm == WM_PHASE && at_top) ||
                              (ctl_q.wm == WM_FAST && at_bottom));

  ocu_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wm(ctl_q.wm), .match(match_evt),
    .count(count), .down(down), .at_top(at_top), .at_bottom(at_bottom)
  );

  ocu_cmp_reg #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr(wr_cmp), .wdata(reg_wdata),
    .buffered(buffered), .xfer(xfer_evt), .active(cmp_active), .shadow(cmp_shadow)
  );

  ocu_flag u_flag (
    .clk(clk), .rst_n(rst_n), .tick(tick), .match(match_evt), .ack(irq_ack),
    .sw_clear(wr_flag && reg_wdata[0]), .flag(flag_q), .pend(pend_q)
  );

  ocu_wavegen u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wm(ctl_q.wm), .om(ctl_q.om),
    .match(match_evt), .at_bottom(at_bottom), .down(down),
    .force_req(force_req), .force_wm(reg_wdata[1:0]), .force_om(reg_wdata[3:2]),
    .wave_q(wave_q), .pin(wave_out)
  );

  assign irq = flag_q && ctl_q.ie;

  always_comb begin
    case (reg_addr)
      RA_CTL:  reg_rdata = W'(ctl_q);
      RA_CMP:  reg_rdata = buffered ? cmp_shadow : cmp_active;
      RA_FLAG: reg_rdata = W'(flag_q);
      default: reg_rdata = count;
    endcase
  end

endmodule

// File: rtl/ocu_checker.sv
module ocu_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [1:0]   wm,
  input logic [W-1:0] count,
  input logic         down,
  input logic         match_evt,
  input logic         xfer_evt,
  input logic         flag_q,
  input logic         pend_q,
  input logic         irq_ack,
  input logic         irq,
  input logic [W-1:0] cmp_active,
  input logic         force_req,
  input logic         force_pwm,
  input logic         wave_q
);

  localparam logic [W-1:0] TOP_VAL = {W{1'b1}};

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  p_ctc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wm == 2'b10 && match_evt) |=> (count == '0));

  p_turn_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wm == 2'b01 && !down && count == TOP_VAL) |=> (down && count == TOP_VAL - 1'b1));

  p_flag_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick));

  p_flag_from_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_q) |=> flag_q);

  p_ack_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(tick && pend_q)) |=> !irq);

  p_buffer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wm[0] && !xfer_evt) |=> $stable(cmp_active));

  p_force_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (force_req && force_pwm && !tick) |=> $stable(wave_q));

endmodule

bind oc_unit ocu_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wm(ctl_q.wm), .count(count),
  .down(down), .match_evt(match_evt), .xfer_evt(xfer_evt), .flag_q(flag_q),
  .pend_q(pend_q), .irq_ack(irq_ack), .irq(irq), .cmp_active(cmp_active),
  .force_req(force_req), .force_pwm(reg_wdata[0]), .wave_q(wave_q)
);

// File: tb/sim_oc_unit.sv
module sim_oc_unit;

  localparam int SEL_COUNT = 0, SEL_WAVE = 1, SEL_IRQ = 2, SEL_RD = 3,
                 SEL_TOP = 4, SEL_BOT = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq_ack = 1'b0;
  logic [7:0] count;
  logic       at_top, at_bottom, irq, wave_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    string req;
    int    sel;
    int    exp;
  } item_t;

  item_t sb[$];

  always #10 clk = ~clk;

  oc_unit #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack), .count(count),
    .at_top(at_top), .at_bottom(at_bottom), .irq(irq), .wave_out(wave_out)
  );

  function automatic int observe(input int sel);
    case (sel)
      SEL_COUNT: return int'(count);
      SEL_WAVE:  return int'(wave_out);
      SEL_IRQ:   return int'(irq);
      SEL_RD:    return int'(reg_rdata);
      SEL_TOP:   return int'(at_top);
      default:   return int'(at_bottom);
    endcase
  endfunction

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    item_t it;
    int act;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      act = observe(it.sel);
      n_checks++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_val(input string req, input int sel, input int exp);
    item_t it;
    it.req = req;
    it.sel = sel;
    it.exp = exp;
    sb.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic expect_rd(input string req, input logic [1:0] a, input int exp);
    reg_addr = a;
    expect_val(req, SEL_RD, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick = 1'b0;
    reg_wr = 1'b0;
    irq_ack = 1'b0;
    repeat (2) cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) cyc();
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state
    do_reset();
    expect_val("R13", SEL_COUNT, 0);
    expect_val("R13", SEL_WAVE, 0);
    expect_val("R13", SEL_IRQ, 0);
    expect_val("R13", SEL_BOT, 1);
    expect_rd("R13", 2'd0, 0);
    expect_rd("R13", 2'd2, 0);

    // counting only on ticks, wrap
    ticks(7);
    expect_val("R1", SEL_COUNT, 7);
    repeat (3) cyc();
    expect_val("R1", SEL_COUNT, 7);
    ticks(250);
    expect_val("R1", SEL_COUNT, 1);
    expect_rd("R1", 2'd3, 1);

    // flag timing, irq, clearing, direct compare write
    do_reset();
    wr(2'd1, 8'd3);
    expect_rd("R8", 2'd1, 3);
    ticks(4);
    expect_rd("R4", 2'd2, 0);
    repeat (2) cyc();
    expect_rd("R4", 2'd2, 0);
    ticks(1);
    expect_rd("R4", 2'd2, 1);
    expect_val("R5", SEL_IRQ, 0);
    wr(2'd0, 8'h10);
    expect_val("R5", SEL_IRQ, 1);
    wr(2'd2, 8'h00);
    expect_rd("R6", 2'd2, 1);
    irq_ack = 1'b1;
    cyc();
    irq_ack = 1'b0;
    expect_rd("R6", 2'd2, 0);
    expect_val("R5", SEL_IRQ, 0);
    ticks(256);
    expect_val("R1", SEL_COUNT, 5);
    expect_rd("R4", 2'd2, 1);
    wr(2'd2, 8'h01);
    expect_rd("R6", 2'd2, 0);
    expect_val("R6", SEL_IRQ, 0);

    // clear-on-match counting and non-PWM pin actions
    do_reset();
    wr(2'd0, 8'h06);
    wr(2'd1, 8'd4);
    ticks(4);
    expect_val("R2", SEL_COUNT, 4);
    expect_val("R9", SEL_WAVE, 0);
    ticks(1);
    expect_val("R2", SEL_COUNT, 0);
    expect_val("R9", SEL_WAVE, 1);
    ticks(5);
    expect_val("R9", SEL_WAVE, 0);
    wr(2'd0, 8'h0E);
    ticks(5);
    expect_val("R9", SEL_WAVE, 1);
    wr(2'd0, 8'h0A);
    ticks(5);
    expect_val("R9", SEL_WAVE, 0);
    wr(2'd0, 8'h0E);
    ticks(5);
    expect_val("R9", SEL_WAVE, 1);
    wr(2'd0, 8'h02);
    expect_val("R9", SEL_WAVE, 0);

    // force strobe
    do_reset();
    wr(2'd0, 8'h8C);
    expect_val("R12", SEL_WAVE, 1);
    expect_rd("R12", 2'd2, 0);
    expect_rd("R12", 2'd0, 8'h0C);
    wr(2'd0, 8'h8B);
    expect_val("R12", SEL_WAVE, 1);
    wr(2'd0, 8'h88);
    expect_val("R12", SEL_WAVE, 0);

    // fast PWM with buffered compare
    do_reset();
    wr(2'd1, 8'd10);
    wr(2'd0, 8'h0B);
    ticks(1);
    expect_val("R10", SEL_WAVE, 1);
    wr(2'd1, 8'd3);
    expect_rd("R7", 2'd1, 3);
    ticks(9);
    expect_val("R7", SEL_COUNT, 10);
    expect_val("R7", SEL_WAVE, 1);
    ticks(1);
    expect_val("R10", SEL_WAVE, 0);
    ticks(246);
    expect_val("R1", SEL_COUNT, 1);
    expect_val("R10", SEL_WAVE, 1);
    ticks(2);
    expect_val("R7", SEL_WAVE, 1);
    ticks(1);
    expect_val("R7", SEL_WAVE, 0);
    wr(2'd0, 8'h0F);
    ticks(252);
    expect_val("R1", SEL_COUNT, 0);
    ticks(1);
    expect_val("R10", SEL_WAVE, 0);
    ticks(3);
    expect_val("R10", SEL_WAVE, 1);

    // phase-correct PWM, inverted output, transfer at top
    do_reset();
    wr(2'd1, 8'd100);
    wr(2'd0, 8'h0D);
    ticks(10);
    wr(2'd1, 8'd200);
    ticks(90);
    expect_val("R11", SEL_WAVE, 0);
    ticks(1);
    expect_val("R7", SEL_WAVE, 1);
    ticks(154);
    expect_val("R3", SEL_TOP, 1);
    ticks(1);
    expect_val("R3", SEL_COUNT, 254);
    ticks(54);
    expect_val("R3", SEL_COUNT, 200);
    expect_val("R11", SEL_WAVE, 1);
    ticks(1);
    expect_val("R11", SEL_WAVE, 0);
    ticks(199);
    expect_val("R3", SEL_BOT, 1);
    ticks(1);
    expect_val("R3", SEL_COUNT, 1);

    cyc();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule